// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block is a small pool of slots that hold dispatched operations until both of their source operands are known. Each slot keeps the operation code, a destination tag, and for each of two sources a tag, a data word and a ready bit. A source whose value already exists at dispatch is stored with its data. A source that is still being produced waits on its tag.

Every cycle, each waiting source compares its tag with the result broadcast bus. On a match it takes the broadcast data and becomes ready. A slot whose sources are both ready is eligible to go to the functional unit. The oldest eligible slot, by dispatch order, is sent out. At most one slot issues per cycle, and slots leave in a different order from the one they arrived in. A flush input empties the pool.

Top module: `rs_station`

## Requirements
- R1: After reset, `full_o` and `issue_valid_o` are low.
- R2: A dispatch is accepted when `disp_valid_i` is high, `full_o` is low and `flush_i` is low. A slot accepted with both sources marked ready drives `issue_valid_o` during the next cycle. In that cycle it presents the dispatched op, both data words and the destination tag.
- R3: A waiting source whose tag equals `bc_tag_i` while `bc_valid_i` is high captures `bc_data_i`. If the other source is ready, the slot issues in the cycle after the broadcast, carrying the captured word.
- R4: A slot with any source not ready never issues. A broadcast whose tag matches no waiting source leaves every slot unchanged.
- R5: A broadcast in the same cycle as a dispatch is captured by the new slot's waiting source when the tags match.
- R6: When several slots are ready, the one dispatched earliest issues first, whatever its slot position.
- R7: At most one slot issues per cycle. An issued slot is freed at the clock edge that ends its issue cycle and never issues again.
- R8: `full_o` is high while all NUM_ENTRIES slots are occupied. A dispatch presented while `full_o` is high is dropped.
- R9: `flush_i` empties every slot at the next edge. A dispatch in the flush cycle is dropped, and later broadcasts revive nothing.
- R10: A younger slot that is ready issues ahead of an older slot that is still waiting.
- R11: A source marked ready at dispatch keeps its dispatched data, even when a later or same-cycle broadcast carries its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all slots |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | OP_W | Operation code |
| disp_s1_tag_i | input | TAG_W | Source 1 tag |
| disp_s1_data_i | input | DATA_W | Source 1 data when ready |
| disp_s1_rdy_i | input | 1 | Source 1 ready at dispatch |
| disp_s2_tag_i | input | TAG_W | Source 2 tag |
| disp_s2_data_i | input | DATA_W | Source 2 data when ready |
| disp_s2_rdy_i | input | 1 | Source 2 ready at dispatch |
| disp_dst_i | input | TAG_W | Destination tag |
| full_o | output | 1 | No free slot |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Result broadcast tag |
| bc_data_i | input | DATA_W | Result broadcast data |
| issue_valid_o | output | 1 | A slot is issuing this cycle |
| issue_op_o | output | OP_W | Issued op |
| issue_s1_o | output | DATA_W | Issued source 1 data |
| issue_s2_o | output | DATA_W | Issued source 2 data |
| issue_dst_o | output | TAG_W | Issued destination tag |

## Verification
Every issue output comes from registered state, with no path from the inputs. A slot that becomes complete at a clock edge shows on `issue_valid_o` in the cycle right after that edge, and it is gone one edge later. The bench changes inputs just after a falling edge and reads results at the next falling edge. Each check therefore sees exactly one edge of effect. A falling-edge monitor records every issue, so the tests can compare both the order of issues and how many there were.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned OP_W   = 4;
  parameter int unsigned TAG_W  = 4;
  parameter int unsigned DATA_W = 16;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    logic              rdy;
  } src_t;

  typedef struct packed {
    logic              vld;
    logic [OP_W-1:0]   op;
    src_t              s1;
    src_t              s2;
    logic [TAG_W-1:0]  dst;
  } entry_t;

  // capture broadcast into a waiting source; ready sources are left alone
  function automatic src_t src_capture(src_t s, logic bv, logic [TAG_W-1:0] bt,
                                       logic [DATA_W-1:0] bd);
    src_t r;
    r = s;
    if (!s.rdy && bv && (bt == s.tag)) begin
      r.rdy  = 1'b1;
      r.data = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_slot.sv
module rs_slot import rs_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [OP_W-1:0]   wr_op_i,
  input  logic [TAG_W-1:0]  wr_s1_tag_i,
  input  logic [DATA_W-1:0] wr_s1_data_i,
  input  logic              wr_s1_rdy_i,
  input  logic [TAG_W-1:0]  wr_s2_tag_i,
  input  logic [DATA_W-1:0] wr_s2_data_i,
  input  logic              wr_s2_rdy_i,
  input  logic [TAG_W-1:0]  wr_dst_i,
  input  logic              clr_i,
  input  logic              bc_vld_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              vld_o,
  output logic              rdy_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] d1_o,
  output logic [DATA_W-1:0] d2_o,
  output logic [TAG_W-1:0]  dst_o
);
  entry_t ent_q;
  src_t   wr_s1, wr_s2;

  assign wr_s1 = '{tag: wr_s1_tag_i, data: wr_s1_data_i, rdy: wr_s1_rdy_i};
  assign wr_s2 = '{tag: wr_s2_tag_i, data: wr_s2_data_i, rdy: wr_s2_rdy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (flush_i) begin
      ent_q <= '0;
    end else if (wr_i) begin
      ent_q.vld <= 1'b1;
      ent_q.op  <= wr_op_i;
      ent_q.dst <= wr_dst_i;
      ent_q.s1  <= src_capture(wr_s1, bc_vld_i, bc_tag_i, bc_data_i);
      ent_q.s2  <= src_capture(wr_s2, bc_vld_i, bc_tag_i, bc_data_i);
    end else if (clr_i) begin
      ent_q.vld <= 1'b0;
    end else if (ent_q.vld) begin
      ent_q.s1 <= src_capture(ent_q.s1, bc_vld_i, bc_tag_i, bc_data_i);
      ent_q.s2 <= src_capture(ent_q.s2, bc_vld_i, bc_tag_i, bc_data_i);
    end
  end

  assign vld_o = ent_q.vld;
  assign rdy_o = ent_q.vld & ent_q.s1.rdy & ent_q.s2.rdy;
  assign op_o  = ent_q.op;
  assign d1_o  = ent_q.s1.data;
  assign d2_o  = ent_q.s2.data;
  assign dst_o = ent_q.dst;
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] vld_i,
  output logic [N-1:0] pick_o,
  output logic         full_o
);
  // lowest-index free slot
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign full_o = &vld_i;
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] ready_i,
  output logic [N-1:0] grant_o
);
  // older_q[i][j] set: slot i was written before slot j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (flush_i) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_i[i])                older_q[i][j] <= 1'b0;
          else if (alloc_i[j] && i != j) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++) blk = blk | (ready_i[j] & older_q[j][i]);
      grant_o[i] = ready_i[i] & ~blk;
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station import rs_pkg::*; #(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              disp_valid_i,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_s1_tag_i,
  input  logic [DATA_W-1:0] disp_s1_data_i,
  input  logic              disp_s1_rdy_i,
  input  logic [TAG_W-1:0]  disp_s2_tag_i,
  input  logic [DATA_W-1:0] disp_s2_data_i,
  input  logic              disp_s2_rdy_i,
  input  logic [TAG_W-1:0]  disp_dst_i,
  output logic              full_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic              issue_valid_o,
  output logic [OP_W-1:0]   issue_op_o,
  output logic [DATA_W-1:0] issue_s1_o,
  output logic [DATA_W-1:0] issue_s2_o,
  output logic [TAG_W-1:0]  issue_dst_o
);
  localparam int unsigned N = NUM_ENTRIES;

  logic [N-1:0] vld_vec, rdy_vec, free_pick, alloc_oh, grant_oh;
  logic [OP_W-1:0]   ent_op  [N];
  logic [DATA_W-1:0] ent_d1  [N];
  logic [DATA_W-1:0] ent_d2  [N];
  logic [TAG_W-1:0]  ent_dst [N];
  logic disp_acc;

  assign disp_acc = disp_valid_i & ~full_o & ~flush_i;
  assign alloc_oh = free_pick & {N{disp_acc}};

  rs_alloc #(.N(N)) u_alloc (
    .vld_i  (vld_vec),
    .pick_o (free_pick),
    .full_o (full_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    rs_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush_i),
      .wr_i         (alloc_oh[g]),
      .wr_op_i      (disp_op_i),
      .wr_s1_tag_i  (disp_s1_tag_i),
      .wr_s1_data_i (disp_s1_data_i),
      .wr_s1_rdy_i  (disp_s1_rdy_i),
      .wr_s2_tag_i  (disp_s2_tag_i),
      .wr_s2_data_i (disp_s2_data_i),
      .wr_s2_rdy_i  (disp_s2_rdy_i),
      .wr_dst_i     (disp_dst_i),
      .clr_i        (grant_oh[g]),
      .bc_vld_i     (bc_valid_i),
      .bc_tag_i     (bc_tag_i),
      .bc_data_i    (bc_data_i),
      .vld_o        (vld_vec[g]),
      .rdy_o        (rdy_vec[g]),
      .op_o         (ent_op[g]),
      .d1_o         (ent_d1[g]),
      .d2_o         (ent_d2[g]),
      .dst_o        (ent_dst[g])
    );
  end

  rs_age #(.N(N)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .alloc_i (alloc_oh),
    .ready_i (rdy_vec),
    .grant_o (grant_oh)
  );

  // grant is one-hot, so an OR mux suffices
  always_comb begin
    issue_op_o  = '0;
    issue_s1_o  = '0;
    issue_s2_o  = '0;
    issue_dst_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_oh[i]) begin
        issue_op_o  = issue_op_o  | ent_op[i];
        issue_s1_o  = issue_s1_o  | ent_d1[i];
        issue_s2_o  = issue_s2_o  | ent_d2[i];
        issue_dst_o = issue_dst_o | ent_dst[i];
      end
    end
  end

  assign issue_valid_o = |grant_oh;
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         flush_i,
  input logic         disp_valid_i,
  input logic         full_o,
  input logic         issue_valid_o,
  input logic [N-1:0] vld_vec,
  input logic [N-1:0] grant_vec
);
  logic acc;
  assign acc = disp_valid_i & ~full_o & ~flush_i;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (!issue_valid_o && !full_o));

  // R7
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant_vec));

  // R4
  empty_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_vec == '0) |-> !issue_valid_o);

  // R7
  issue_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !acc && !flush_i) |=> ($countones(vld_vec) == $past($countones(vld_vec)) - 1));

  // R2
  accept_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !issue_valid_o) |=> ($countones(vld_vec) == $past($countones(vld_vec)) + 1));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !issue_valid_o && !flush_i) |=> full_o);

  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_vec == '0));
endmodule

bind rs_station rs_station_chk #(.N(NUM_ENTRIES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .disp_valid_i  (disp_valid_i),
  .full_o        (full_o),
  .issue_valid_o (issue_valid_o),
  .vld_vec       (vld_vec),
  .grant_vec     (grant_oh)
);

// File: tb/tb_rs_station.sv
`timescale 1ns/1ps
module tb_rs_station;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic dv = 1'b0, s1r = 1'b0, s2r = 1'b0;
  logic [3:0] op = '0, t1 = '0, t2 = '0, dst = '0;
  logic [15:0] d1 = '0, d2 = '0;
  logic bv = 1'b0;
  logic [3:0] bt = '0;
  logic [15:0] bd = '0;
  logic full, iv;
  logic [3:0] iop, idst;
  logic [15:0] is1, is2;

  int checks = 0, fails = 0, n_log = 0, cyc = 0;
  logic [3:0]  lg_op [64];
  logic [3:0]  lg_dst[64];
  logic [15:0] lg_s1 [64];
  logic [15:0] lg_s2 [64];
  int          lg_cyc[64];

  always #5 clk = ~clk;

  rs_station #(.NUM_ENTRIES(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .disp_valid_i(dv), .disp_op_i(op),
    .disp_s1_tag_i(t1), .disp_s1_data_i(d1), .disp_s1_rdy_i(s1r),
    .disp_s2_tag_i(t2), .disp_s2_data_i(d2), .disp_s2_rdy_i(s2r),
    .disp_dst_i(dst), .full_o(full),
    .bc_valid_i(bv), .bc_tag_i(bt), .bc_data_i(bd),
    .issue_valid_o(iv), .issue_op_o(iop), .issue_s1_o(is1),
    .issue_s2_o(is2), .issue_dst_o(idst)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n && iv && n_log < 64) begin
      lg_op[n_log] = iop; lg_dst[n_log] = idst;
      lg_s1[n_log] = is1; lg_s2[n_log] = is2;
      lg_cyc[n_log] = cyc;
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); #1; endtask

  task automatic idle;
    dv = 1'b0; bv = 1'b0; flush = 1'b0;
  endtask

  task automatic disp(input logic [3:0] o, input logic [3:0] a_t, input logic [15:0] a_d,
                      input logic a_r, input logic [3:0] b_t, input logic [15:0] b_d,
                      input logic b_r, input logic [3:0] ds);
    dv = 1'b1; op = o; t1 = a_t; d1 = a_d; s1r = a_r;
    t2 = b_t; d2 = b_d; s2r = b_r; dst = ds;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [15:0] d);
    bv = 1'b1; bt = t; bd = d;
  endtask

  task automatic sweep_case(input bit r1, input bit r2, input bit fwd);
    int base, c;
    logic [15:0] e1, e2;
    bit s1ok;
    c = {29'd0, r1, r2, fwd};
    e1 = 16'h1100 + 16'(c);
    e2 = 16'h2200 + 16'(c);
    base = n_log;
    s1ok = r1 | fwd;
    disp(4'(c), 4'd3, r1 ? e1 : 16'hBAD0, r1, 4'd5, r2 ? e2 : 16'hBAD1, r2, 4'd7);
    if (fwd) bcast(4'd3, r1 ? ~e1 : e1);
    tick; idle;
    if (r1 && r2)  chk(iv == 1'b1, "R2 ready at dispatch", iv, 1);
    else if (fwd)  chk(iv == (s1ok && r2), "R5 same-cycle capture", iv, s1ok && r2);
    else           chk(iv == 1'b0, "R4 waiting slot issued", iv, 0);
    bcast(r1 ? 4'd3 : 4'd9, 16'hDEAD);
    tick; idle;
    chk(iv == 1'b0, "R4 unrelated broadcast", iv, 0);
    if (!s1ok) begin
      bcast(4'd3, e1); tick; idle;
      chk(iv == r2, "R3 wake on tag 1", iv, r2);
    end
    if (!r2) begin
      bcast(4'd5, e2); tick; idle;
      chk(iv == 1'b1, "R3 wake on tag 2", iv, 1);
    end
    tick;
    chk(n_log == base + 1, "R7 exactly one issue", n_log - base, 1);
    chk(lg_op[base] == 4'(c) && lg_dst[base] == 4'd7, "R2 op and dst", lg_op[base], c);
    chk(lg_s1[base] == e1, "R11 source 1 data", lg_s1[base], e1);
    chk(lg_s2[base] == e2, "R3 source 2 data", lg_s2[base], e2);
    chk(iv == 1'b0 && full == 1'b0, "R7 slot freed", iv, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    idle;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk(full == 1'b0 && iv == 1'b0, "R1 reset state", {full, iv}, 0);

    for (int k = 0; k < 8; k++) sweep_case(k[2], k[1], k[0]);

    // age order and out-of-order issue
    base = n_log;
    disp(4'd1, 4'd8, 16'h0, 1'b0, 4'd0, 16'hA001, 1'b1, 4'd1); tick;
    disp(4'd2, 4'd6, 16'h0, 1'b0, 4'd0, 16'hA002, 1'b1, 4'd2); tick;
    disp(4'd3, 4'd0, 16'hB003, 1'b1, 4'd0, 16'hA003, 1'b1, 4'd3); tick; idle;
    chk(iv && idst == 4'd3, "R10 younger ready first", idst, 3);
    bcast(4'd8, 16'hC008); tick; idle;
    chk(iv && idst == 4'd1 && is1 == 16'hC008, "R3 capture on tag 8", is1, 16'hC008);
    tick;
    disp(4'd4, 4'd6, 16'h0, 1'b0, 4'd0, 16'hA004, 1'b1, 4'd4); tick; idle;
    bcast(4'd6, 16'hC006); tick; idle;
    chk(iv && idst == 4'd2, "R6 oldest of two ready", idst, 2);
    tick;
    chk(iv && idst == 4'd4, "R6 younger follows", idst, 4);
    tick;
    chk(!iv && n_log == base + 4, "R7 one per cycle", n_log - base, 4);
    chk(lg_cyc[base + 3] == lg_cyc[base + 2] + 1, "R7 back-to-back issue",
        lg_cyc[base + 3] - lg_cyc[base + 2], 1);

    // fill, drop while full, drain in age order
    base = n_log;
    for (int k = 0; k < 4; k++) begin
      disp(4'(k), 4'd10, 16'h0, 1'b0, 4'd0, 16'h5000 + 16'(k), 1'b1, 4'(8 + k)); tick;
    end
    idle;
    chk(full == 1'b1, "R8 full after four", full, 1);
    disp(4'd15, 4'd0, 16'h1, 1'b1, 4'd0, 16'h2, 1'b1, 4'd15); tick; idle;
    chk(full == 1'b1 && iv == 1'b0, "R8 dispatch dropped", iv, 0);
    bcast(4'd10, 16'hE00A); tick; idle;
    for (int k = 0; k < 4; k++) begin
      chk(iv && idst == 4'(8 + k), "R6 drain order", idst, 8 + k);
      tick;
      if (k == 0) chk(full == 1'b0, "R8 full clears", full, 0);
    end
    chk(!iv && n_log == base + 4, "R8 no extra issue", n_log - base, 4);

    // flush
    base = n_log;
    disp(4'd5, 4'd11, 16'h0, 1'b0, 4'd0, 16'h1, 1'b1, 4'd5); tick;
    disp(4'd6, 4'd11, 16'h0, 1'b0, 4'd0, 16'h1, 1'b1, 4'd6); tick;
    flush = 1'b1;
    disp(4'd7, 4'd0, 16'h1, 1'b1, 4'd0, 16'h1, 1'b1, 4'd7); tick; idle;
    chk(!iv && !full, "R9 flush empties", iv, 0);
    bcast(4'd11, 16'h7777); tick; idle;
    chk(!iv, "R9 no revival", iv, 0);
    tick;
    chk(n_log == base, "R9 nothing issued", n_log - base, 0);
    disp(4'd9, 4'd0, 16'h9, 1'b1, 4'd0, 16'h9, 1'b1, 4'd9); tick; idle;
    chk(iv && idst == 4'd9, "R9 dispatch after flush", idst, 9);
    tick;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule